// File: doc/BRIEF.md
# Outbound Address Translation Window Unit

This block turns a CPU-side memory address into an outbound bus address. The CPU region that starts at a fixed base is cut into a row of equal windows. Their size is a power of two in megabytes, set by a 3-bit code. Each window carries its own 32-bit target base with an enable flag in bit 0, plus a 32-bit upper word. A lookup request returns a hit flag, the index of the window that was hit and a 64-bit translated address, one clock after the request.

Software programs the block through a simple 32-bit register write port and can read every register back through a combinational read port. One command word holds two bits: the global translation enable and an alternate-view select. The alternate-view bit is driven out to the surrounding logic and is visible on readback in the same cycle that it takes effect.

A separate setup word holds the routing fields for configuration accesses: bus, device, function and a type-1 flag. These fields are driven straight out as ports.

Top module: `obx_xlat_top`

## Requirements
- R1: After synchronous reset every register reads as zero, `rsp_vld_o` is 0, translation is disabled and the window size code is 0 (1 MiB).
- R2: Offset 0x030 holds the window size code in its low 3 bits, so a window spans 2^code MiB. The upper bits of a write are dropped and read back as zero.
- R3: For a request address A, the selected window is (A - REGION_BASE) >> (20 + code). The translated low word is that window's low register with bit 0 cleared, plus the offset of A inside the window.
- R4: On a hit, bits 63:32 of `rsp_addr_o` equal the selected window's upper word, written at offset 0x204 + 8n.
- R5: Window n's low register sits at offset 0x200 + 8n. Its bit 0 enables the window, and a disabled window produces a miss.
- R6: Bit 1 of the command word at offset 0x004 is the global translation enable. While it is 0, every request misses.
- R7: On a miss, `rsp_hit_o` is 0, `rsp_idx_o` is 0 and `rsp_addr_o` is the request address zero-extended to 64 bits.
- R8: An address below REGION_BASE, or at or beyond NUM_WIN windows above it, misses.
- R9: The setup word at offset 0x008 holds bus in bits 23:16, device in bits 12:8, function in bits 2:0 and the type-1 flag in bit 24. These fields appear on the `cfg_*` outputs and change only when offset 0x008 is written.
- R10: Bit 5 of the command word drives `alt_view_o`. The output and the readback of offset 0x004 take the new value in the cycle after the write.
- R11: `rsp_vld_o` is high exactly in the cycle after a cycle in which `req_i` is high.
- R12: Window registers read back as written. Offsets that are not mapped read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Register write byte offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 12 | Register read byte offset |
| rd_data_o | output | 32 | Combinational read data |
| req_i | input | 1 | Lookup request |
| req_addr_i | input | 32 | CPU-side address to translate |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| rsp_hit_o | output | 1 | Address fell in an enabled window while enabled |
| rsp_idx_o | output | 5 | Index of the hit window |
| rsp_addr_o | output | 64 | Translated or passed-through address |
| xlat_en_o | output | 1 | Global translation enable |
| alt_view_o | output | 1 | Alternate register view select |
| cfg_bus_o | output | 8 | Configuration target bus |
| cfg_dev_o | output | 5 | Configuration target device |
| cfg_fn_o | output | 3 | Configuration target function |
| cfg_type1_o | output | 1 | Type-1 configuration select |

## Verification
Some properties are checked on every cycle:
- the one-cycle response timing;
- the pass-through form of a miss;
- that a hit only follows a cycle in which the global enable was set;
- that the alternate-view bit follows a command write;
- that the setup fields hold steady between their writes.

Other behaviours only the bench scenarios can show, because they depend on what was programmed earlier:
- the window arithmetic: which index is chosen and how base and offset combine across size codes;
- window edges and the last window;
- per-window enables;
- readback of the stored fields.

// File: rtl/obx_pkg.sv
package obx_pkg;

    localparam int          REG_AW     = 12;
    localparam int          DW         = 32;
    localparam logic [11:0] CMD_OFS    = 12'h004;
    localparam logic [11:0] SETUP_OFS  = 12'h008;
    localparam logic [11:0] SIZE_OFS   = 12'h030;
    localparam logic [11:0] WIN_OFS    = 12'h200;
    localparam int          XLAT_BIT   = 1;
    localparam int          ALT_BIT    = 5;
    localparam int          MB_SHIFT   = 20;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
    } win_t;

    typedef struct packed {
        logic       type1;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
    } setup_t;

    typedef struct packed {
        logic        hit;
        logic [4:0]  idx;
        logic [63:0] addr;
    } xres_t;

    function automatic logic is_win_reg(input logic [11:0] a, input int unsigned n);
        logic [11:0] rel;
        rel = a - WIN_OFS;
        return (a >= WIN_OFS) && (a[1:0] == 2'b00) && (32'(rel >> 3) < n);
    endfunction

    function automatic logic [11:0] win_slot(input logic [11:0] a);
        return (a - WIN_OFS) >> 3;
    endfunction

endpackage

// File: rtl/obx_regfile.sv
module obx_regfile
    import obx_pkg::*;
#(
    parameter int NUM_WIN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [11:0] wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [11:0] rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        xlat_en_o,
    output logic        alt_view_o,
    output logic [2:0]  size_code_o,
    output setup_t      setup_o,
    output win_t        win_o [NUM_WIN]
);
    localparam int IDX_W = $clog2(NUM_WIN);

    logic        wr_win;
    logic [11:0] wr_slot;

    assign wr_win  = wr_en_i && is_win_reg(wr_addr_i, NUM_WIN);
    assign wr_slot = win_slot(wr_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            xlat_en_o   <= 1'b0;
            alt_view_o  <= 1'b0;
            size_code_o <= '0;
            setup_o     <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == CMD_OFS) begin
                xlat_en_o  <= wr_data_i[XLAT_BIT];
                alt_view_o <= wr_data_i[ALT_BIT];
            end
            if (wr_addr_i == SIZE_OFS) begin
                size_code_o <= wr_data_i[2:0];
            end
            if (wr_addr_i == SETUP_OFS) begin
                setup_o.type1 <= wr_data_i[24];
                setup_o.bus   <= wr_data_i[23:16];
                setup_o.dev   <= wr_data_i[12:8];
                setup_o.fn    <= wr_data_i[2:0];
            end
        end
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        win_t slot_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr_win && (wr_slot == 12'(g))) begin
                if (wr_addr_i[2]) slot_q.hi <= wr_data_i;
                else              slot_q.lo <= wr_data_i;
            end
        end
        assign win_o[g] = slot_q;
    end

    logic [11:0] rd_slot;
    assign rd_slot = win_slot(rd_addr_i);

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == CMD_OFS) begin
            rd_data_o[XLAT_BIT] = xlat_en_o;
            rd_data_o[ALT_BIT]  = alt_view_o;
        end else if (rd_addr_i == SIZE_OFS) begin
            rd_data_o[2:0] = size_code_o;
        end else if (rd_addr_i == SETUP_OFS) begin
            rd_data_o[24]    = setup_o.type1;
            rd_data_o[23:16] = setup_o.bus;
            rd_data_o[12:8]  = setup_o.dev;
            rd_data_o[2:0]   = setup_o.fn;
        end else if (is_win_reg(rd_addr_i, NUM_WIN)) begin
            rd_data_o = rd_addr_i[2] ? win_o[rd_slot[IDX_W-1:0]].hi
                                     : win_o[rd_slot[IDX_W-1:0]].lo;
        end
    end

    // R10: the alternate view follows a command write one cycle later
    assert_alt_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == CMD_OFS) |=> (alt_view_o == $past(wr_data_i[ALT_BIT])));

    // R9: setup fields move only on a write to the setup word
    assert_setup_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && wr_addr_i == SETUP_OFS) |=> $stable(setup_o));

endmodule

// File: rtl/obx_lookup.sv
module obx_lookup
    import obx_pkg::*;
#(
    parameter int          NUM_WIN     = 32,
    parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
    input  logic [31:0] addr_i,
    input  logic        xlat_en_i,
    input  logic [2:0]  size_code_i,
    input  win_t        win_i [NUM_WIN],
    output xres_t       res_o
);
    localparam int IDX_W = $clog2(NUM_WIN);

    int          shift;
    logic [31:0] rel;
    logic [31:0] slot;
    logic [31:0] off_mask;
    logic        in_range;
    logic [IDX_W-1:0] idx;
    win_t        sel;

    always_comb begin
        shift    = MB_SHIFT + int'(size_code_i);
        rel      = addr_i - REGION_BASE;
        slot     = rel >> shift;
        off_mask = (32'h1 << shift) - 32'h1;
        in_range = (addr_i >= REGION_BASE) && (slot < 32'(NUM_WIN));
        idx      = slot[IDX_W-1:0];
        sel      = win_i[idx];

        res_o = '0;
        if (xlat_en_i && in_range && sel.lo[0]) begin
            res_o.hit  = 1'b1;
            res_o.idx  = 5'(idx);
            res_o.addr = {sel.hi, ({sel.lo[31:1], 1'b0} + (rel & off_mask))};
        end else begin
            res_o.addr = {32'h0, addr_i};
        end
    end

endmodule

// File: rtl/obx_xlat_top.sv
module obx_xlat_top
    import obx_pkg::*;
#(
    parameter int          NUM_WIN     = 32,
    parameter logic [31:0] REGION_BASE = 32'h4000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en_i,
    input  logic [11:0] wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [11:0] rd_addr_i,
    output logic [31:0] rd_data_o,
    input  logic        req_i,
    input  logic [31:0] req_addr_i,
    output logic        rsp_vld_o,
    output logic        rsp_hit_o,
    output logic [4:0]  rsp_idx_o,
    output logic [63:0] rsp_addr_o,
    output logic        xlat_en_o,
    output logic        alt_view_o,
    output logic [7:0]  cfg_bus_o,
    output logic [4:0]  cfg_dev_o,
    output logic [2:0]  cfg_fn_o,
    output logic        cfg_type1_o
);
    logic [2:0] size_code;
    setup_t     setup;
    win_t       win [NUM_WIN];
    xres_t      lk_res;
    xres_t      rsp_q;

    obx_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .xlat_en_o  (xlat_en_o),
        .alt_view_o (alt_view_o),
        .size_code_o(size_code),
        .setup_o    (setup),
        .win_o      (win)
    );

    obx_lookup #(.NUM_WIN(NUM_WIN), .REGION_BASE(REGION_BASE)) u_lookup (
        .addr_i     (req_addr_i),
        .xlat_en_i  (xlat_en_o),
        .size_code_i(size_code),
        .win_i      (win),
        .res_o      (lk_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld_o <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_vld_o <= req_i;
            if (req_i) rsp_q <= lk_res;
        end
    end

    assign rsp_hit_o   = rsp_q.hit;
    assign rsp_idx_o   = rsp_q.idx;
    assign rsp_addr_o  = rsp_q.addr;
    assign cfg_bus_o   = setup.bus;
    assign cfg_dev_o   = setup.dev;
    assign cfg_fn_o    = setup.fn;
    assign cfg_type1_o = setup.type1;

    // R11: a response follows each request cycle and nothing else
    assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (rst)
        req_i |=> rsp_vld_o);
    assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !rsp_vld_o);

    // R7: a miss hands back the untranslated request address
    assert_miss_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld_o && !rsp_hit_o) |-> (rsp_addr_o == {32'h0, $past(req_addr_i)} && rsp_idx_o == 5'd0));

    // R6: a hit requires the global enable in the request cycle
    assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld_o && rsp_hit_o) |-> $past(xlat_en_o));

endmodule

// File: tb/obx_xlat_top_tb.sv
module obx_xlat_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_vld, rsp_hit;
    logic [4:0]  rsp_idx;
    logic [63:0] rsp_addr;
    logic        xlat_en, alt_view;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic        cfg_type1;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    obx_xlat_top u_dut (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .req_i(req), .req_addr_i(req_addr),
        .rsp_vld_o(rsp_vld), .rsp_hit_o(rsp_hit), .rsp_idx_o(rsp_idx), .rsp_addr_o(rsp_addr),
        .xlat_en_o(xlat_en), .alt_view_o(alt_view),
        .cfg_bus_o(cfg_bus), .cfg_dev_o(cfg_dev), .cfg_fn_o(cfg_fn), .cfg_type1_o(cfg_type1)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        hit;
        logic [4:0]  idx;
        logic [63:0] exp;
    } vec_t;

    // 8 MiB windows (code 3) above base 0x4000_0000
    localparam vec_t VEC [9] = '{
        '{32'h4000_0000, 1'b1, 5'd0,  64'h0000_0000_8000_0000},  // R3 window start
        '{32'h4012_3456, 1'b1, 5'd0,  64'h0000_0000_8012_3456},  // R3 offset
        '{32'h407F_FFFC, 1'b1, 5'd0,  64'h0000_0000_807F_FFFC},  // R3 last word
        '{32'h4080_0010, 1'b1, 5'd1,  64'h0000_0012_9000_0010},  // R4 upper word
        '{32'h4100_0004, 1'b0, 5'd0,  64'h0000_0000_4100_0004},  // R5 disabled
        '{32'h4F80_0100, 1'b1, 5'd31, 64'h0000_ABCD_F000_0100},  // R8 last window
        '{32'h5000_0000, 1'b0, 5'd0,  64'h0000_0000_5000_0000},  // R8 beyond
        '{32'h3FFF_FFFF, 1'b0, 5'd0,  64'h0000_0000_3FFF_FFFF},  // R8 below
        '{32'h4280_0000, 1'b0, 5'd0,  64'h0000_0000_4280_0000}   // R5 never enabled
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic xl(input logic [31:0] a, output logic h, output logic [4:0] i, output logic [63:0] o);
        @(negedge clk);
        req = 1'b1; req_addr = a;
        @(negedge clk);
        h = rsp_hit; i = rsp_idx; o = rsp_addr;
        chk("R11 valid after request", 64'(rsp_vld), 64'd1);
        req = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        h;
        logic [4:0]  i;
        logic [63:0] o;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h004, d); chk("R1 cmd", 64'(d), 64'd0);
        rd(12'h030, d); chk("R1 size", 64'(d), 64'd0);
        rd(12'h200, d); chk("R1 win0", 64'(d), 64'd0);
        chk("R1 rsp_vld", 64'(rsp_vld), 64'd0);
        chk("R1 xlat_en", 64'(xlat_en), 64'd0);

        // program windows
        wr(12'h030, 32'h0000_0003);
        wr(12'h200, 32'h8000_0001);
        wr(12'h204, 32'h0000_0000);
        wr(12'h208, 32'h9000_0001);
        wr(12'h20C, 32'h0000_0012);
        wr(12'h210, 32'hA000_0000);
        wr(12'h2F8, 32'hF000_0001);
        wr(12'h2FC, 32'h0000_ABCD);

        // R6 disabled globally: everything misses
        xl(32'h4000_0000, h, i, o);
        chk("R6 hit while off", 64'(h), 64'd0);
        chk("R6 addr while off", o, 64'h0000_0000_4000_0000);

        wr(12'h004, 32'h0000_0002);
        chk("R6 enable out", 64'(xlat_en), 64'd1);

        for (int k = 0; k < 9; k++) begin
            xl(VEC[k].a, h, i, o);
            chk("R3/R4/R5/R7/R8 hit", 64'(h), 64'(VEC[k].hit));
            chk("R3/R7 idx", 64'(i), 64'(VEC[k].idx));
            chk("R3/R4/R7 addr", o, VEC[k].exp);
        end

        // R11 no valid without request
        @(negedge clk);
        chk("R11 idle", 64'(rsp_vld), 64'd0);

        // R2 size change, upper bits dropped
        wr(12'h030, 32'hFFFF_FFF9);
        rd(12'h030, d); chk("R2 size readback", 64'(d), 64'd1);
        xl(32'h4020_0004, h, i, o);
        chk("R2 hit 2MiB", 64'(h), 64'd1);
        chk("R2 idx 2MiB", 64'(i), 64'd1);
        chk("R2 addr 2MiB", o, 64'h0000_0012_9000_0004);

        // R12 readback and unmapped offsets
        rd(12'h20C, d); chk("R12 win1 hi", 64'(d), 64'h12);
        rd(12'h2F8, d); chk("R12 win31 lo", 64'(d), 64'hF000_0001);
        wr(12'h100, 32'hDEAD_BEEF);
        rd(12'h100, d); chk("R12 unmapped", 64'(d), 64'd0);

        // R9 configuration setup word
        wr(12'h008, 32'h0103_0A05);
        chk("R9 bus", 64'(cfg_bus), 64'h03);
        chk("R9 dev", 64'(cfg_dev), 64'h0A);
        chk("R9 fn", 64'(cfg_fn), 64'h5);
        chk("R9 type1", 64'(cfg_type1), 64'd1);
        rd(12'h008, d); chk("R9 readback", 64'(d), 64'h0103_0A05);

        // R10 alternate view: output and readback agree after the write
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h004; wr_data = 32'h0000_0022;
        rd_addr = 12'h004;
        #1 chk("R10 before edge", 64'(alt_view), 64'd0);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10 alt out", 64'(alt_view), 64'd1);
        chk("R10 readback", 64'(rd_data), 64'h22);
        wr(12'h004, 32'h0000_0002);
        chk("R10 alt cleared", 64'(alt_view), 64'd0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule